// File: doc/BRIEF.md
# Interrupt Priority Arbitration Controller

This block holds the pending and in-service state for the 256 interrupt vectors of one processor core and decides which vector, if any, may be delivered next. Three 256-bit maps are kept: a request map, an in-service map and a trigger-mode map. Each is split into 32-bit words, and vector v sits in word v/32 at bit v mod 32. Vectors are grouped into priority classes of sixteen by their upper nibble.

Requests arrive on a vector/trigger input and are taken only while both the hardware enable pin and the software enable bit are set. The core writes a task priority, reads the presented vector and its valid flag, and pulses an acknowledge to move the presented vector from the request map to the in-service map. An end-of-interrupt write retires the highest in-service vector. If that vector was level-triggered, a one-cycle broadcast pulse carries its number to the interrupt sources. The processor priority derived from the task priority and the in-service state is also an output.

Top module: `prio_arb_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all three maps, the task priority and the software enable bit are clear, and `int_valid`, `ppr` and `eoi_bcast` are 0.
- R2: When enabled, a request sets the request bit of `req_vec`. It sets the trigger-mode bit when `req_level`=1 and clears it when `req_level`=0. `req_accept` is high in the request's cycle exactly when the request bit was clear.
- R3: A level request for a vector whose request bit is already set changes nothing and gives `req_accept`=0. An edge request in that case clears the trigger-mode bit and also gives `req_accept`=0.
- R4: A request is ignored unless `hw_en`=1 and the software enable bit is 1. That bit is bit 8 of `ctl_wdata`, loaded when `ctl_wr`=1.
- R5: `int_vec` is the highest set vector in the request map, found by scanning the words from the top down and taking the most significant set bit.
- R6: `ppr` equals the task priority when its upper nibble is at least the upper nibble of the highest in-service vector. Otherwise it equals that vector with the low nibble zeroed. An empty in-service map counts as vector 0.
- R7: `int_valid` is 1 only when a vector is pending and that vector with its low nibble zeroed is strictly greater than `ppr`.
- R8: An `ack` while `int_valid`=1 sets the in-service bit of `int_vec`, clears its request bit and raises `ppr` accordingly.
- R9: `eoi_wr` clears the highest in-service bit. If that vector's trigger-mode bit was set, the bit is cleared and `eoi_bcast` pulses for one cycle with the vector on `eoi_bcast_vec`.
- R10: `eoi_wr` with an empty in-service map changes no state and raises no broadcast.
- R11: When `ack` and a request for the presented vector fall in the same cycle, the acknowledge is applied first. The request then sees a clear request bit, is accepted, and sets the request bit again.
- R12: Outputs are registered. The edge after a state update presents the new arbitration, and `int_valid` is 0 in the cycle between. An `ack` while `int_valid`=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Hardware enable for request acceptance |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 9 | Control word; bit 8 is the software enable |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_accept | output | 1 | Request taken as a new pending interrupt (same cycle) |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| ack | input | 1 | Core acknowledge of the presented vector |
| int_valid | output | 1 | Presented vector is deliverable |
| int_vec | output | 8 | Highest pending vector |
| ppr | output | 8 | Processor priority |
| eoi_bcast | output | 1 | One-cycle end-of-interrupt broadcast for a level vector |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
The acknowledge and a new request can fall in the same cycle for the same vector. Their order decides whether the request is seen as a duplicate. The bench waits until a vector is presented, then drives `ack` and a level request for that vector on the same falling edge. A correct result has `req_accept` high, `ppr` raised to the vector's class with nothing presented, and the same vector presented again after an end-of-interrupt with a broadcast. Sweeps over every vector and every task-priority class check the delivery and priority rules against values computed in the bench.

// File: rtl/prio_arb_pkg.sv
// Shared constants for the interrupt priority arbitration controller.
// Assumes vectors are grouped into classes by their upper bits above CLASS_W.
package prio_arb_pkg;
    // Number of low vector bits inside one priority class.
    localparam int CLASS_W  = 4;
    // Position of the software enable bit in the control word.
    localparam int SWEN_BIT = 8;
endpackage

// File: rtl/vec_word_msb.sv
// Finds the most significant set bit of one map word.
// Assumes WORD_W is a power of two; idx is meaningless when any is 0.
module vec_word_msb #(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    // Priority encode: later (higher) set bits override earlier ones.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if (word[b]) begin
                any = 1'b1;
                idx = b[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/vec_map_finder.sv
// Returns the highest set vector of a map split into WORD_W-bit words.
// Each word is encoded in parallel; the highest non-empty word wins.
// Assumes NUM_VEC is a multiple of WORD_W with at least two words.
module vec_map_finder #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    localparam int VEC_W     = $clog2(NUM_VEC),
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int IDX_W     = $clog2(WORD_W),
    localparam int WSEL_W    = $clog2(NUM_WORDS)
) (
    input  logic [NUM_VEC-1:0] map,
    output logic               found,
    output logic [VEC_W-1:0]   vec
);
    logic [NUM_WORDS-1:0] word_any;
    logic [IDX_W-1:0]     word_idx [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        vec_word_msb #(.WORD_W(WORD_W)) enc_i (
            .word (map[w*WORD_W +: WORD_W]),
            .any  (word_any[w]),
            .idx  (word_idx[w])
        );
    end

    // Select the topmost non-empty word and join its index to the word number.
    always_comb begin
        found = 1'b0;
        vec   = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_any[w]) begin
                found = 1'b1;
                vec   = {w[WSEL_W-1:0], word_idx[w]};
            end
        end
    end
endmodule

// File: rtl/prio_resolver.sv
// Derives the processor priority from the task priority and the highest
// in-service vector, and decides whether the highest pending vector may be
// delivered. Purely combinational; the caller registers the results.
module prio_resolver
    import prio_arb_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_vec,
    input  logic             irr_found,
    input  logic [VEC_W-1:0] irr_vec,
    output logic [VEC_W-1:0] ppr,
    output logic             deliver
);
    logic [VEC_W-1:0] isr_eff;
    logic [VEC_W-1:0] irr_floor;

    // Processor priority: task priority unless a higher class is in service.
    always_comb begin
        isr_eff = isr_found ? isr_vec : '0;
        if (tpr[VEC_W-1:CLASS_W] >= isr_eff[VEC_W-1:CLASS_W])
            ppr = tpr;
        else
            ppr = {isr_eff[VEC_W-1:CLASS_W], {CLASS_W{1'b0}}};
    end

    // Delivery: the pending vector's class floor must exceed the priority.
    always_comb begin
        irr_floor = {irr_vec[VEC_W-1:CLASS_W], {CLASS_W{1'b0}}};
        deliver   = irr_found && (irr_floor > ppr);
    end
endmodule

// File: rtl/prio_arb_ctrl.sv
// Interrupt priority arbitration controller: keeps request, in-service and
// trigger-mode maps, presents the highest deliverable vector and retires
// in-service vectors on end-of-interrupt. Within one cycle, end-of-interrupt
// acts first, then acknowledge, then the incoming request. Outputs are
// registered; int_valid is held low in the cycle after any state update.
module prio_arb_ctrl
    import prio_arb_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32,
    localparam int NUM_VEC = 2 ** VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_en,
    input  logic               ctl_wr,
    input  logic [SWEN_BIT:0]  ctl_wdata,
    input  logic               req_valid,
    input  logic [VEC_W-1:0]   req_vec,
    input  logic               req_level,
    output logic               req_accept,
    input  logic               tpr_wr,
    input  logic [VEC_W-1:0]   tpr_wdata,
    input  logic               eoi_wr,
    input  logic               ack,
    output logic               int_valid,
    output logic [VEC_W-1:0]   int_vec,
    output logic [VEC_W-1:0]   ppr,
    output logic               eoi_bcast,
    output logic [VEC_W-1:0]   eoi_bcast_vec
);
    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
    logic [VEC_W-1:0]   tpr_q, tpr_n;
    logic               swen_q;
    logic               irr_found, isr_found;
    logic [VEC_W-1:0]   irr_top, isr_top;
    logic [VEC_W-1:0]   ppr_c;
    logic               deliver_c;
    logic               state_chg;
    logic               bcast_n;
    logic               ack_take;
    logic               req_take;

    vec_map_finder #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) irr_find_i (
        .map (irr_q), .found (irr_found), .vec (irr_top)
    );

    vec_map_finder #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) isr_find_i (
        .map (isr_q), .found (isr_found), .vec (isr_top)
    );

    prio_resolver #(.VEC_W(VEC_W)) resolve_i (
        .tpr       (tpr_q),
        .isr_found (isr_found),
        .isr_vec   (isr_top),
        .irr_found (irr_found),
        .irr_vec   (irr_top),
        .ppr       (ppr_c),
        .deliver   (deliver_c)
    );

    assign ack_take = ack && int_valid;
    assign req_take = req_valid && hw_en && swen_q;

    // Next map state: end-of-interrupt, then acknowledge, then request.
    always_comb begin
        irr_n      = irr_q;
        isr_n      = isr_q;
        tmr_n      = tmr_q;
        bcast_n    = 1'b0;
        req_accept = 1'b0;
        if (eoi_wr && isr_found) begin
            isr_n[isr_top] = 1'b0;
            if (tmr_q[isr_top]) begin
                tmr_n[isr_top] = 1'b0;
                bcast_n        = 1'b1;
            end
        end
        if (ack_take) begin
            isr_n[int_vec] = 1'b1;
            irr_n[int_vec] = 1'b0;
        end
        if (req_take) begin
            req_accept = !irr_n[req_vec];
            if (!(irr_n[req_vec] && req_level)) begin
                irr_n[req_vec] = 1'b1;
                tmr_n[req_vec] = req_level;
            end
        end
    end

    // Next task priority and detection of any arbitration-relevant change.
    always_comb begin
        tpr_n     = tpr_wr ? tpr_wdata : tpr_q;
        state_chg = (irr_n != irr_q) || (isr_n != isr_q) || (tpr_n != tpr_q);
    end

    // Map and task-priority registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
            tpr_q <= '0;
        end else begin
            irr_q <= irr_n;
            isr_q <= isr_n;
            tmr_q <= tmr_n;
            tpr_q <= tpr_n;
        end
    end

    // Software enable bit from the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            swen_q <= 1'b0;
        else if (ctl_wr)
            swen_q <= ctl_wdata[SWEN_BIT];
    end

    // Registered arbitration outputs, suppressed while state is moving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_valid <= 1'b0;
            int_vec   <= '0;
            ppr       <= '0;
        end else begin
            int_valid <= deliver_c && !state_chg;
            int_vec   <= irr_top;
            ppr       <= ppr_c;
        end
    end

    // One-cycle end-of-interrupt broadcast for level-triggered vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bcast     <= 1'b0;
            eoi_bcast_vec <= '0;
        end else begin
            eoi_bcast     <= bcast_n;
            eoi_bcast_vec <= bcast_n ? isr_top : eoi_bcast_vec;
        end
    end

    // An accepted request leaves its request bit set.
    assert_accept_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> irr_q[$past(req_vec)]);

    // The top in-service index reported by the finder is really set.
    assert_isr_top_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        isr_found |-> isr_q[isr_top]);

    // An honoured acknowledge puts the presented vector in service.
    assert_ack_in_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_valid) |=> isr_q[$past(int_vec)]);

    // A broadcast only follows an end-of-interrupt write.
    assert_bcast_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> $past(eoi_wr));

    // End-of-interrupt on an empty in-service map leaves it empty.
    assert_eoi_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && (isr_q == '0) && !(ack && int_valid)) |=> (isr_q == '0) && !eoi_bcast);

    // A presented vector is always still pending.
    assert_presented_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> irr_q[int_vec]);

    // An acknowledge without a valid presentation moves nothing into service.
    assert_ack_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_valid && !eoi_wr) |=> $stable(isr_q));
endmodule

// File: tb/prio_arb_ctrl_tb_top.sv
module prio_arb_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 180000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [8:0] ctl_wdata = '0;
    logic       req_valid = 1'b0;
    logic [7:0] req_vec = '0;
    logic       req_level = 1'b0;
    logic       req_accept;
    logic       tpr_wr = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       eoi_wr = 1'b0;
    logic       ack = 1'b0;
    logic       int_valid;
    logic [7:0] int_vec;
    logic [7:0] ppr;
    logic       eoi_bcast;
    logic [7:0] eoi_bcast_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_arb_ctrl dut_i (
        .clk, .rst_n, .hw_en, .ctl_wr, .ctl_wdata, .req_valid, .req_vec,
        .req_level, .req_accept, .tpr_wr, .tpr_wdata, .eoi_wr, .ack,
        .int_valid, .int_vec, .ppr, .eoi_bcast, .eoi_bcast_vec
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic do_ctl(input logic [8:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_tpr(input logic [7:0] t);
        tpr_wr = 1'b1; tpr_wdata = t;
        @(negedge clk); tpr_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_req(input logic [7:0] v, input logic lvl, output logic acc);
        req_valid = 1'b1; req_vec = v; req_level = lvl;
        #1 acc = req_accept;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_eoi(output logic seen, output logic [7:0] bv);
        eoi_wr = 1'b1;
        @(negedge clk); eoi_wr = 1'b0;
        seen = eoi_bcast; bv = eoi_bcast_vec;
        @(negedge clk);
        check("R9 broadcast lasts one cycle", int'(eoi_bcast), 0);
    endtask

    function automatic logic [7:0] exp_ppr(input logic [7:0] t, input logic [7:0] a);
        return (t[7:4] >= a[7:4]) ? t : {a[7:4], 4'h0};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic acc;
        logic seen;
        logic [7:0] bv;

        // R1: reset state, including clearing of earlier pending state.
        hw_en = 1'b1;
        do_reset();
        @(negedge clk);
        check("R1 int_valid after reset", int'(int_valid), 0);
        check("R1 ppr after reset", int'(ppr), 0);
        check("R1 eoi_bcast after reset", int'(eoi_bcast), 0);
        do_req(8'h80, 1'b0, acc);
        check("R1 software enable clear after reset", int'(acc), 0);
        do_ctl(9'h100);
        do_tpr(8'h35);
        do_req(8'h90, 1'b0, acc);
        do_reset();
        do_ctl(9'h100);
        @(negedge clk);
        check("R1 request map cleared", int'(int_valid), 0);
        check("R1 task priority cleared", int'(ppr), 0);

        // R4: both enables required.
        do_reset();
        hw_en = 1'b0;
        do_ctl(9'h100);
        do_req(8'h80, 1'b0, acc);
        check("R4 hw_en low rejects", int'(acc), 0);
        check("R4 hw_en low no pending", int'(int_valid), 0);
        hw_en = 1'b1;
        do_ctl(9'h0FF);
        do_req(8'h80, 1'b0, acc);
        check("R4 sw enable low rejects", int'(acc), 0);
        check("R4 sw enable low no pending", int'(int_valid), 0);
        do_ctl(9'h100);
        do_req(8'h80, 1'b0, acc);
        check("R4 both enables accept", int'(acc), 1);
        check("R4 both enables pending", int'(int_valid), 1);

        // R3: level duplicate discarded, trigger bit kept.
        do_reset(); do_ctl(9'h100);
        do_req(8'h70, 1'b1, acc);
        check("R2 level request accepted", int'(acc), 1);
        do_req(8'h70, 1'b1, acc);
        check("R3 level duplicate not accepted", int'(acc), 0);
        do_ack();
        check("R8 ppr after ack", int'(ppr), 8'h70);
        do_eoi(seen, bv);
        check("R3 trigger bit kept, broadcast", int'(seen), 1);
        check("R9 broadcast vector", int'(bv), 8'h70);
        check("R9 ppr after eoi", int'(ppr), 0);

        // R3: edge duplicate clears the trigger bit.
        do_reset(); do_ctl(9'h100);
        do_req(8'h71, 1'b1, acc);
        do_req(8'h71, 1'b0, acc);
        check("R3 edge duplicate not accepted", int'(acc), 0);
        do_ack();
        do_eoi(seen, bv);
        check("R3 edge duplicate cleared trigger bit", int'(seen), 0);

        // R5/R9: ordering across words and nested service.
        do_reset(); do_ctl(9'h100);
        do_req(8'h21, 1'b0, acc);
        do_req(8'h9F, 1'b0, acc);
        do_req(8'hE0, 1'b0, acc);
        do_req(8'h45, 1'b0, acc);
        check("R5 highest of four", int'(int_vec), 8'hE0);
        do_ack();
        check("R7 nothing above in-service class", int'(int_valid), 0);
        check("R6 ppr from in-service", int'(ppr), 8'hE0);
        do_eoi(seen, bv);
        check("R5 next highest", int'(int_vec), 8'h9F);
        do_ack(); do_eoi(seen, bv);
        check("R5 third highest", int'(int_vec), 8'h45);
        do_ack();
        do_req(8'h4A, 1'b0, acc);
        check("R7 same class not delivered", int'(int_valid), 0);
        do_req(8'h52, 1'b0, acc);
        check("R7 higher class delivered", int'(int_vec), 8'h52);
        check("R7 higher class valid", int'(int_valid), 1);
        do_ack();
        check("R8 nested ppr", int'(ppr), 8'h50);
        do_eoi(seen, bv);
        check("R9 eoi retires highest in-service", int'(ppr), 8'h40);
        check("R9 edge vector no broadcast", int'(seen), 0);

        // R10: end-of-interrupt with nothing in service.
        do_reset(); do_ctl(9'h100);
        do_req(8'h30, 1'b1, acc);
        do_eoi(seen, bv);
        check("R10 no broadcast", int'(seen), 0);
        check("R10 pending kept", int'(int_vec), 8'h30);
        check("R10 still valid", int'(int_valid), 1);
        check("R10 ppr unchanged", int'(ppr), 0);

        // R12: ack during the blank cycle is ignored.
        do_reset(); do_ctl(9'h100);
        req_valid = 1'b1; req_vec = 8'h60; req_level = 1'b0;
        @(negedge clk); req_valid = 1'b0;
        check("R12 valid low after update", int'(int_valid), 0);
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        @(negedge clk);
        check("R12 ignored ack keeps pending", int'(int_valid), 1);
        check("R12 ignored ack vector", int'(int_vec), 8'h60);
        check("R12 ignored ack ppr", int'(ppr), 0);

        // R11: acknowledge and request of the same vector together.
        do_reset(); do_ctl(9'h100);
        do_req(8'h50, 1'b0, acc);
        ack = 1'b1; req_valid = 1'b1; req_vec = 8'h50; req_level = 1'b1;
        #1 acc = req_accept;
        @(negedge clk); ack = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        check("R11 request accepted after ack", int'(acc), 1);
        check("R11 ppr raised", int'(ppr), 8'h50);
        check("R11 same class blocked", int'(int_valid), 0);
        do_eoi(seen, bv);
        check("R11 level request set trigger bit", int'(seen), 1);
        check("R11 request bit set again", int'(int_vec), 8'h50);
        check("R11 presented again", int'(int_valid), 1);

        // Sweep: every pending vector against every task-priority class.
        for (int v = 0; v < 256; v++) begin
            for (int t = 0; t < 16; t++) begin
                logic [7:0] tp;
                logic [7:0] vv;
                tp = {t[3:0], 4'(v * 7)};
                vv = v[7:0];
                do_reset(); do_ctl(9'h100);
                do_tpr(tp);
                do_req(vv, 1'b0, acc);
                check("R2 sweep accept", int'(acc), 1);
                check("R7 sweep delivery", int'(int_valid), int'({vv[7:4], 4'h0} > tp));
                if ({vv[7:4], 4'h0} > tp)
                    check("R5 sweep vector", int'(int_vec), int'(vv));
                check("R6 sweep ppr empty isr", int'(ppr), int'(tp));
            end
        end

        // Sweep: every in-service vector against every task-priority class.
        for (int a = 16; a < 256; a++) begin
            for (int t = 0; t < 16; t++) begin
                logic [7:0] tp;
                logic [7:0] av;
                tp = {t[3:0], 4'(a + t)};
                av = a[7:0];
                do_reset(); do_ctl(9'h100);
                do_req(av, 1'b0, acc);
                do_ack();
                do_tpr(tp);
                check("R6 sweep ppr with isr", int'(ppr), int'(exp_ppr(tp, av)));
                do_eoi(seen, bv);
                check("R9 sweep edge no broadcast", int'(seen), 0);
                check("R9 sweep ppr after eoi", int'(ppr), int'(tp));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule